// File: doc/BRIEF.md
# DMA Channel Source Address Sequencer

This block keeps the source address of every channel of a multi-channel DMA engine and moves it forward as the transfer engine reports progress. Software reaches the addresses, the bus-error status bit and its interrupt enable through a small register port. The transfer engine supplies single-cycle strobes for read cycle done, block done and bus error, together with the channel they concern, the transfer size and a descriptor address for chained blocks.

After every read cycle the selected channel's address is stepped by its counting mode. In chain mode, a completed block loads the channel's address from the descriptor value presented with the block-done strobe. A bus error sets a sticky status bit and asserts a halt request at once. A transfer still in flight (transfer busy high) may run to its end; after that the sequencer sits idle and ignores all progress strobes until software clears the status bit. It does this whether or not the interrupt is enabled.

A three-state machine controls the error behaviour. The states are RUN (normal), DRAIN (error pending while a transfer finishes) and HALT (idle). The transitions are:
- RUN to DRAIN on a bus error while busy.
- RUN to HALT on a bus error while not busy.
- DRAIN to HALT when busy falls.
- DRAIN to RUN, or HALT to RUN, once the status bit is cleared with no new error in the same cycle.

Top module: `dma_srcaddr_seq`

## Requirements
- R1: After reset every channel address reads 0, the status/enable word reads 0, and irq_o, halt_o and idle_o are 0.
- R2: Register offsets 0 to 7 read channel n's address in bits 31:0, with bits 63:32 always 0. A write stores wdata[31:0], and the upper write bits are discarded.
- R3: A read-done strobe for channel ev_chan changes only that channel. Mode 00 adds xfer_size modulo 2^32. Mode 01 subtracts it modulo 2^32. Modes 10 and 11 leave the address unchanged. The mode of channel n is ch_mode[2n+1:2n].
- R4: A block-done strobe on a channel whose ch_chain bit is 1 loads reload_addr, and this wins over a read-done in the same cycle. With ch_chain 0, block done alone leaves the address unchanged.
- R5: A software write to a channel address in the same cycle as a hardware update of that channel stores the written value.
- R6: A bus error sets the status bit, read at offset 8 bit 0. Writing offset 8 with bit 0 = 0 clears it, and bit 0 = 1 leaves it unchanged. A bus error in the same cycle as a clear leaves it set. Offset 8 bit 1 is the interrupt enable, read/write.
- R7: irq_o equals status AND enable.
- R8: halt_o equals the status bit, independent of the enable.
- R9: While status is set and xfer_busy stays 1, progress strobes still update addresses. Once xfer_busy has been seen 0, idle_o is 1 and progress strobes are ignored until the status is cleared, after which updates resume. This holds with the enable at 0 as well.
- R10: A bus error while xfer_busy is 0 makes idle_o 1 after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset: 0-7 channel address, 8 status/enable |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data (combinational) |
| ch_mode | input | 16 | Counting mode, 2 bits per channel |
| ch_chain | input | 8 | Chain enable per channel |
| ev_chan | input | 3 | Channel addressed by the progress strobes |
| rd_done | input | 1 | Read cycle from source completed |
| blk_done | input | 1 | Whole block completed |
| bus_err | input | 1 | Bus error flagged |
| xfer_busy | input | 1 | A transfer is still in flight |
| xfer_size | input | 8 | Step size in bytes for the read cycle |
| reload_addr | input | 32 | Descriptor address for chain reload |
| irq_o | output | 1 | Bus-error interrupt |
| halt_o | output | 1 | Request to start no new transfer |
| idle_o | output | 1 | Sequencer halted, strobes ignored |

## Verification
The hardest situation to reach is DRAIN: an error is pending, yet addresses must keep moving until busy falls, and only then may they freeze. The bench holds xfer_busy high across the error strobe with the enable at 0. It applies read-done strobes and checks that they still count, drops busy, and checks that idle rises and that later strobes leave the address untouched. Clearing the status then shows that counting resumes. A same-cycle clear and error checks that the set wins.

// File: rtl/dma_sa_pkg.sv
package dma_sa_pkg;
    typedef enum logic [1:0] {
        CM_INC = 2'b00,
        CM_DEC = 2'b01,
        CM_FIX = 2'b10,
        CM_RSV = 2'b11
    } cnt_mode_e;

    typedef enum logic [1:0] {
        ST_RUN   = 2'b00,
        ST_DRAIN = 2'b01,
        ST_HALT  = 2'b10
    } err_state_e;
endpackage

// File: rtl/dma_sa_chan.sv
module dma_sa_chan
    import dma_sa_pkg::*;
#(
    parameter int AW  = 32,
    parameter int SZW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sw_we,
    input  logic [AW-1:0]  sw_data,
    input  logic           hw_hit,
    input  logic           rd_done,
    input  logic           blk_done,
    input  logic           chain_en,
    input  cnt_mode_e      mode,
    input  logic [SZW-1:0] xfer_size,
    input  logic [AW-1:0]  reload_addr,
    output logic [AW-1:0]  addr_q
);
    logic [AW-1:0] step;
    logic [AW-1:0] counted;
    logic [AW-1:0] addr_d;
    logic          do_reload;

    assign step      = AW'(xfer_size);
    assign do_reload = hw_hit && blk_done && chain_en;

    always_comb begin
        unique case (mode)
            CM_INC:  counted = addr_q + step;
            CM_DEC:  counted = addr_q - step;
            CM_FIX:  counted = addr_q;
            CM_RSV:  counted = addr_q;
            default: counted = addr_q;
        endcase
    end

    always_comb begin
        if (sw_we)
            addr_d = sw_data;
        else if (do_reload)
            addr_d = reload_addr;
        else if (hw_hit && rd_done)
            addr_d = counted;
        else
            addr_d = addr_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            addr_q <= '0;
        else
            addr_q <= addr_d;
    end

    // R5: software write wins
    a_r5_sw_wins: assert property (@(posedge clk) disable iff (!rst_n)
        sw_we |=> addr_q == $past(sw_data));

    // R3: fixed modes hold on a plain read-done
    a_r3_fixed_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_hit && rd_done && !sw_we && !(blk_done && chain_en) && mode[1])
        |=> $stable(addr_q));

    // R3: increment mode steps up
    a_r3_inc_step: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_hit && rd_done && !sw_we && !(blk_done && chain_en) && mode == CM_INC)
        |=> addr_q == $past(addr_q) + AW'($past(xfer_size)));

    // R4: chain reload takes the descriptor value
    a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_we && hw_hit && blk_done && chain_en) |=> addr_q == $past(reload_addr));

    // R9: without an accepted event or write the address is stable
    a_r9_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_we && !hw_hit) |=> $stable(addr_q));
endmodule

// File: rtl/dma_sa_errctl.sv
module dma_sa_errctl
    import dma_sa_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bus_err,
    input  logic xfer_busy,
    input  logic stat_we,
    input  logic wr_stat_bit,
    input  logic wr_en_bit,
    output logic status_q,
    output logic enable_q,
    output logic accept,
    output logic irq_o,
    output logic halt_o,
    output logic idle_o
);
    err_state_e state_q;
    err_state_e state_d;
    logic       status_d;

    always_comb begin
        status_d = status_q;
        if (stat_we && !wr_stat_bit)
            status_d = 1'b0;
        if (bus_err)
            status_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= 1'b0;
            enable_q <= 1'b0;
        end else begin
            status_q <= status_d;
            if (stat_we)
                enable_q <= wr_en_bit;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (status_d)
                    state_d = xfer_busy ? ST_DRAIN : ST_HALT;
            end
            ST_DRAIN: begin
                if (!status_d)
                    state_d = ST_RUN;
                else if (!xfer_busy)
                    state_d = ST_HALT;
            end
            ST_HALT: begin
                if (!status_d)
                    state_d = ST_RUN;
            end
            default: state_d = ST_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_RUN;
        else
            state_q <= state_d;
    end

    always_comb begin
        accept = 1'b1;
        idle_o = 1'b0;
        unique case (state_q)
            ST_RUN:   accept = 1'b1;
            ST_DRAIN: accept = 1'b1;
            ST_HALT: begin
                accept = 1'b0;
                idle_o = 1'b1;
            end
            default: begin
                accept = 1'b0;
                idle_o = 1'b1;
            end
        endcase
        halt_o = status_q;
        irq_o  = status_q && enable_q;
    end

    // R6: an error always leaves the status set
    a_r6_err_sets: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |=> status_q);

    // R10: error without a busy transfer halts next cycle
    a_r10_direct_halt: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_err && !xfer_busy) |=> idle_o);

    // R9: idle only while an error is pending
    a_r9_idle_needs_err: assert property (@(posedge clk) disable iff (!rst_n)
        idle_o |-> halt_o);

    // R9: running state never carries a pending error
    a_r9_run_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |-> !status_q);

    // R7: interrupt implies pending error
    a_r7_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (halt_o && enable_q));
endmodule

// File: rtl/dma_sa_regif.sv
module dma_sa_regif #(
    parameter int N_CH = 8,
    parameter int AW   = 32,
    parameter int DW   = 64,
    parameter int RAW  = 4
) (
    input  logic              reg_we,
    input  logic [RAW-1:0]    reg_addr,
    input  logic [N_CH*AW-1:0] addr_flat,
    input  logic              status_q,
    input  logic              enable_q,
    output logic [N_CH-1:0]   chan_we,
    output logic              stat_we,
    output logic [DW-1:0]     reg_rdata
);
    localparam int STAT_OFS = N_CH;

    always_comb begin
        chan_we = '0;
        stat_we = 1'b0;
        if (reg_we) begin
            if (int'(reg_addr) < N_CH)
                chan_we[reg_addr] = 1'b1;
            else if (int'(reg_addr) == STAT_OFS)
                stat_we = 1'b1;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (int'(reg_addr) < N_CH)
            reg_rdata[AW-1:0] = addr_flat[reg_addr*AW +: AW];
        else if (int'(reg_addr) == STAT_OFS)
            reg_rdata[1:0] = {enable_q, status_q};
    end

    // R2: at most one target per write
    a_r2_one_target: assert property (@(posedge reg_we)
        $onehot0({chan_we, stat_we}));
endmodule

// File: rtl/dma_srcaddr_seq.sv
module dma_srcaddr_seq
    import dma_sa_pkg::*;
#(
    parameter int N_CH = 8,
    parameter int AW   = 32,
    parameter int DW   = 64,
    parameter int SZW  = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        reg_we,
    input  logic [$clog2(N_CH):0]       reg_addr,
    input  logic [DW-1:0]               reg_wdata,
    output logic [DW-1:0]               reg_rdata,
    input  logic [2*N_CH-1:0]           ch_mode,
    input  logic [N_CH-1:0]             ch_chain,
    input  logic [$clog2(N_CH)-1:0]     ev_chan,
    input  logic                        rd_done,
    input  logic                        blk_done,
    input  logic                        bus_err,
    input  logic                        xfer_busy,
    input  logic [SZW-1:0]              xfer_size,
    input  logic [AW-1:0]               reload_addr,
    output logic                        irq_o,
    output logic                        halt_o,
    output logic                        idle_o
);
    localparam int CHW = $clog2(N_CH);
    localparam int RAW = CHW + 1;

    logic [N_CH*AW-1:0] addr_flat;
    logic [N_CH-1:0]    chan_we;
    logic               stat_we;
    logic               status_q;
    logic               enable_q;
    logic               accept;

    dma_sa_regif #(.N_CH(N_CH), .AW(AW), .DW(DW), .RAW(RAW)) regif_i (
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .addr_flat (addr_flat),
        .status_q  (status_q),
        .enable_q  (enable_q),
        .chan_we   (chan_we),
        .stat_we   (stat_we),
        .reg_rdata (reg_rdata)
    );

    dma_sa_errctl errctl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_err     (bus_err),
        .xfer_busy   (xfer_busy),
        .stat_we     (stat_we),
        .wr_stat_bit (reg_wdata[0]),
        .wr_en_bit   (reg_wdata[1]),
        .status_q    (status_q),
        .enable_q    (enable_q),
        .accept      (accept),
        .irq_o       (irq_o),
        .halt_o      (halt_o),
        .idle_o      (idle_o)
    );

    for (genvar g = 0; g < N_CH; g++) begin : g_chan
        logic hit;
        assign hit = accept && (int'(ev_chan) == g);

        dma_sa_chan #(.AW(AW), .SZW(SZW)) chan_i (
            .clk         (clk),
            .rst_n       (rst_n),
            .sw_we       (chan_we[g]),
            .sw_data     (reg_wdata[AW-1:0]),
            .hw_hit      (hit),
            .rd_done     (rd_done),
            .blk_done    (blk_done),
            .chain_en    (ch_chain[g]),
            .mode        (cnt_mode_e'(ch_mode[2*g +: 2])),
            .xfer_size   (xfer_size),
            .reload_addr (reload_addr),
            .addr_q      (addr_flat[g*AW +: AW])
        );
    end

    // R2: upper read bits stay zero
    a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[DW-1:AW] == '0);

    // R8: halt follows the pending error regardless of the enable
    a_r8_halt_irq: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> halt_o);
endmodule

// File: tb/dma_srcaddr_seq_tb_top.sv
module dma_srcaddr_seq_tb_top;
    localparam int N_CH = 8;
    localparam int AW   = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic [15:0] ch_mode = '0;
    logic [7:0]  ch_chain = '0;
    logic [2:0]  ev_chan = '0;
    logic        rd_done = 1'b0;
    logic        blk_done = 1'b0;
    logic        bus_err = 1'b0;
    logic        xfer_busy = 1'b0;
    logic [7:0]  xfer_size = '0;
    logic [31:0] reload_addr = '0;
    logic        irq_o, halt_o, idle_o;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] model [N_CH];

    dma_srcaddr_seq dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ch_mode(ch_mode),
        .ch_chain(ch_chain), .ev_chan(ev_chan), .rd_done(rd_done),
        .blk_done(blk_done), .bus_err(bus_err), .xfer_busy(xfer_busy),
        .xfer_size(xfer_size), .reload_addr(reload_addr),
        .irq_o(irq_o), .halt_o(halt_o), .idle_o(idle_o)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a, output logic [63:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic chk_ch(input string req, input int c);
        logic [63:0] v;
        rd(4'(c), v);
        chk(req, v, {32'h0, model[c]});
    endtask

    task automatic wr(input logic [3:0] a, input logic [63:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic ev(input int c, input logic r, input logic b, input logic [7:0] sz);
        ev_chan = 3'(c); rd_done = r; blk_done = b; xfer_size = sz;
        @(negedge clk);
        rd_done = 1'b0; blk_done = 1'b0;
    endtask

    task automatic err_pulse();
        bus_err = 1'b1;
        @(negedge clk);
        bus_err = 1'b0;
    endtask

    initial begin
        #1600000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [63:0] v;
        logic [7:0]  sizes [3];
        sizes[0] = 8'd1; sizes[1] = 8'd4; sizes[2] = 8'd255;
        for (int i = 0; i < N_CH; i++) model[i] = '0;

        #2;
        // R1: reset state
        for (int i = 0; i < N_CH; i++) chk_ch("R1", i);
        rd(4'd8, v); chk("R1", v, 64'h0);
        chk("R1", {61'h0, irq_o, halt_o, idle_o}, 64'h0);
        @(negedge clk); rst_n = 1'b1; @(negedge clk);

        // R2: upper write bits discarded, reads zero-extend
        wr(4'd3, 64'hDEAD_BEEF_1234_5678);
        model[3] = 32'h1234_5678;
        chk_ch("R2", 3);
        rd(4'd12, v); chk("R2", v, 64'h0);

        // R3: sweep channels, modes and sizes
        for (int c = 0; c < N_CH; c++) begin
            for (int m = 0; m < 4; m++) begin
                ch_mode = '0;
                ch_mode[2*c +: 2] = 2'(m);
                for (int s = 0; s < 3; s++) begin
                    logic [31:0] start;
                    start = (s == 0) ? 32'hFFFF_FFFE : ((s == 1) ? 32'h0000_0002 : 32'h8000_0000 + 32'(c));
                    wr(4'(c), {32'hFFFF_FFFF, start});
                    model[c] = start;
                    for (int k = 0; k < 3; k++) begin
                        ev(c, 1'b1, 1'b0, sizes[s]);
                        if (m == 0) model[c] = model[c] + 32'(sizes[s]);
                        else if (m == 1) model[c] = model[c] - 32'(sizes[s]);
                        chk_ch("R3", c);
                    end
                    chk_ch("R3", (c + 1) % N_CH);
                end
            end
        end
        ch_mode = '0;

        // R4: chain reload wins over read-done
        ch_chain = 8'b0010_0000;
        reload_addr = 32'hCAFE_0040;
        ev(5, 1'b1, 1'b1, 8'd8);
        model[5] = 32'hCAFE_0040;
        chk_ch("R4", 5);
        // R4: no chain -> block done alone holds
        reload_addr = 32'h1111_1111;
        ev(6, 1'b0, 1'b1, 8'd8);
        chk_ch("R4", 6);
        ev(6, 1'b1, 1'b1, 8'd8);
        model[6] = model[6] + 32'd8;
        chk_ch("R4", 6);
        ch_chain = '0;

        // R5: software write beats hardware update
        reg_we = 1'b1; reg_addr = 4'd2; reg_wdata = 64'h0000_0000_ABCD_0000;
        ev_chan = 3'd2; rd_done = 1'b1; xfer_size = 8'd16;
        @(negedge clk);
        reg_we = 1'b0; rd_done = 1'b0;
        model[2] = 32'hABCD_0000;
        chk_ch("R5", 2);

        // R6, R7, R8, R10: enable on, error while not busy
        wr(4'd8, 64'h2);
        rd(4'd8, v); chk("R6", v, 64'h2);
        chk("R7", {63'h0, irq_o}, 64'h0);
        err_pulse();
        rd(4'd8, v); chk("R6", v, 64'h3);
        chk("R7", {63'h0, irq_o}, 64'h1);
        chk("R8", {63'h0, halt_o}, 64'h1);
        chk("R10", {63'h0, idle_o}, 64'h1);
        wr(4'd8, 64'h3);
        rd(4'd8, v); chk("R6", v, 64'h3);
        // R9: strobes ignored while halted
        ch_chain = 8'b0000_0010; reload_addr = 32'h5555_0000;
        ev(1, 1'b1, 1'b1, 8'd4);
        ev(2, 1'b1, 1'b0, 8'd4);
        chk_ch("R9", 1);
        chk_ch("R9", 2);
        ch_chain = '0;
        // R6: clear and error together -> set wins
        reg_we = 1'b1; reg_addr = 4'd8; reg_wdata = 64'h2; bus_err = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; bus_err = 1'b0;
        rd(4'd8, v); chk("R6", v, 64'h3);
        wr(4'd8, 64'h2);
        rd(4'd8, v); chk("R6", v, 64'h2);
        chk("R7", {61'h0, irq_o, halt_o, idle_o}, 64'h0);

        // R9, R8: enable off, error during a busy transfer
        wr(4'd8, 64'h0);
        xfer_busy = 1'b1;
        err_pulse();
        chk("R8", {63'h0, halt_o}, 64'h1);
        chk("R7", {63'h0, irq_o}, 64'h0);
        chk("R9", {63'h0, idle_o}, 64'h0);
        ev(4, 1'b1, 1'b0, 8'd32);
        model[4] = model[4] + 32'd32;
        chk_ch("R9", 4);
        xfer_busy = 1'b0;
        @(negedge clk);
        chk("R9", {63'h0, idle_o}, 64'h1);
        ev(4, 1'b1, 1'b0, 8'd32);
        chk_ch("R9", 4);
        wr(4'd8, 64'h0);
        chk("R9", {62'h0, halt_o, idle_o}, 64'h0);
        ev(4, 1'b1, 1'b0, 8'd32);
        model[4] = model[4] + 32'd32;
        chk_ch("R9", 4);

        // R1/R2 sanity on all channels at end
        for (int i = 0; i < N_CH; i++) chk_ch("R2", i);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule